// File: doc/BRIEF.md
# Dual Address Arithmetic Unit

This block computes data-memory addresses for indirect operand access. It holds two identical address arithmetic units. Each unit keeps its own pointer, offset and modifier registers, and it can advance its pointer once in every clock cycle. Both units run in parallel, so the block yields two 16-bit addresses per cycle.

The modifier register sets how the offset is added to the pointer. An all-ones modifier gives plain two's-complement addition. A modifier of zero gives reverse-carry addition, which is used to walk FFT data in bit-reversed order. A value from 1 to 0x7FFF gives a circular buffer of that value plus one entries. Addressing is post-modify: a unit presents its current pointer as the address, and the updated pointer takes effect at the clock edge that ends the cycle.

A controller writes a unit's registers with a load strobe and requests pointer updates with a step strobe. The memory and instruction decode are outside this block.

Top module: `addr_gen_dual`

## Requirements
- R1: The two units are independent. Strobes and write data for one unit never change the address or next-pointer outputs of the other unit.
- R2: When `load_i[u]` is high at a clock edge, unit u writes its pointer, offset and modifier from the write-data inputs. From the next cycle, `addr_o[u]` equals the loaded pointer. Load has priority over step in the same cycle.
- R3: With modifier 0xFFFF, the next pointer is (pointer + offset) mod 2^16, with the offset taken as two's complement.
- R4: With modifier M in 1..0x7FFF, the buffer size is M+1. Let k be the smallest value with 2^k >= M+1. The base is the pointer with its low k bits cleared, and the valid range is base..base+M. A sum above base+M has M+1 subtracted. A sum below base has M+1 added. Any other sum is kept. This holds for a pointer inside the range and an offset with magnitude at most M+1.
- R5: With modifier 0, the next pointer is pointer plus offset with the carry running from bit 15 toward bit 0. A carry out of bit 0 is dropped. Starting at 0 with offset N/2, successive steps visit 0..N-1 in bit-reversed order.
- R6: `addr_o[u]` is the pointer before the update. `nxt_o[u]` shows the updated value during the same cycle. When `step_i[u]` is high and `load_i[u]` is low, the pointer takes the `nxt_o[u]` value at the clock edge.
- R7: With neither load nor step, the pointer of a unit holds its value.
- R8: Modifier values 0x8000 to 0xFFFE are treated as linear, the same as 0xFFFF.
- R9: After reset, every pointer and offset is 0 and every modifier is 0xFFFF. Both outputs of each unit then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 2 | Per-unit register write strobe |
| step_i | input | 2 | Per-unit pointer update strobe |
| ptr_wdata_i | input | 2x16 | Per-unit pointer write data |
| off_wdata_i | input | 2x16 | Per-unit offset write data |
| mod_wdata_i | input | 2x16 | Per-unit modifier write data |
| addr_o | output | 2x16 | Per-unit address (pointer before update) |
| nxt_o | output | 2x16 | Per-unit updated pointer |

## Verification
The directed cases are chosen to separate the arithmetic paths:
- Linear cases wrap across 0xFFFF.
- Modulo cases force an upper wrap and a lower wrap, which shows whether the buffer size is added or subtracted and whether the base is found by masking.
- A reverse-carry walk from zero with offset 4 must give 0,4,2,6,1,5,3,7. Forward carry would give a different order.

Random traffic then mixes all four modifier classes across both units, including load and step in the same cycle. This exposes any priority mistakes and any leakage between the units.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_LIN = 2'd0,
    MODE_MOD = 2'd1,
    MODE_REV = 2'd2
  } agu_mode_e;
endpackage

// File: rtl/agu_revcarry_add.sv
module agu_revcarry_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] a_rev, b_rev, s_rev;

  // mirror operands so an ordinary adder carries high-to-low
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign a_rev[i] = a_i[W-1-i];
    assign b_rev[i] = b_i[W-1-i];
    assign sum_o[i] = s_rev[W-1-i];
  end

  assign s_rev = a_rev + b_rev;
endmodule

// File: rtl/agu_modulo_add.sv
module agu_modulo_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] ptr_i,
  input  logic [W-1:0] off_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] sum_o
);
  logic        [W-1:0] mask, base;
  logic        [W:0]   upper, size;
  logic signed [W+1:0] raw, hi, lo, fix;

  // smallest all-ones mask covering the modifier
  always_comb begin
    mask = mod_i;
    for (int i = 1; i < W; i++) mask = mask | (mod_i >> i);
  end

  assign base  = ptr_i & ~mask;
  assign upper = {1'b0, base} + {1'b0, mod_i};
  assign size  = {1'b0, mod_i} + {{W{1'b0}}, 1'b1};
  assign raw   = $signed({2'b00, ptr_i}) + $signed({{2{off_i[W-1]}}, off_i});
  assign hi    = $signed({1'b0, upper});
  assign lo    = $signed({2'b00, base});

  always_comb begin
    if (raw > hi)      fix = raw - $signed({1'b0, size});
    else if (raw < lo) fix = raw + $signed({1'b0, size});
    else               fix = raw;
  end

  assign sum_o = fix[W-1:0];
endmodule

// File: rtl/agu_unit.sv
module agu_unit
  import agu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] ptr_wdata_i,
  input  logic [W-1:0] off_wdata_i,
  input  logic [W-1:0] mod_wdata_i,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] ptr_q, off_q, mod_q;
  logic [W-1:0] lin_sum, mod_sum, rev_sum;
  agu_mode_e    mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      off_q <= '0;
      mod_q <= '1;
    end else if (load_i) begin
      ptr_q <= ptr_wdata_i;
      off_q <= off_wdata_i;
      mod_q <= mod_wdata_i;
    end else if (step_i) begin
      ptr_q <= nxt_o;
    end
  end

  always_comb begin
    if (mod_q == '0)          mode = MODE_REV;
    else if (!mod_q[W-1])     mode = MODE_MOD;
    else                      mode = MODE_LIN;  // all ones and reserved upper half
  end

  assign lin_sum = ptr_q + off_q;

  agu_modulo_add #(.W(W)) u_mod (
    .ptr_i (ptr_q),
    .off_i (off_q),
    .mod_i (mod_q),
    .sum_o (mod_sum)
  );

  agu_revcarry_add #(.W(W)) u_rev (
    .a_i   (ptr_q),
    .b_i   (off_q),
    .sum_o (rev_sum)
  );

  always_comb begin
    unique case (mode)
      MODE_MOD: nxt_o = mod_sum;
      MODE_REV: nxt_o = rev_sum;
      default:  nxt_o = lin_sum;
    endcase
  end

  assign addr_o = ptr_q;
endmodule

// File: rtl/addr_gen_dual.sv
module addr_gen_dual #(
  parameter int W = 16,
  parameter int N = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        load_i,
  input  logic [N-1:0]        step_i,
  input  logic [N-1:0][W-1:0] ptr_wdata_i,
  input  logic [N-1:0][W-1:0] off_wdata_i,
  input  logic [N-1:0][W-1:0] mod_wdata_i,
  output logic [N-1:0][W-1:0] addr_o,
  output logic [N-1:0][W-1:0] nxt_o
);
  for (genvar u = 0; u < N; u++) begin : g_unit
    agu_unit #(.W(W)) u_unit (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load_i[u]),
      .step_i      (step_i[u]),
      .ptr_wdata_i (ptr_wdata_i[u]),
      .off_wdata_i (off_wdata_i[u]),
      .mod_wdata_i (mod_wdata_i[u]),
      .addr_o      (addr_o[u]),
      .nxt_o       (nxt_o[u])
    );
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int W = 16,
  parameter int N = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N-1:0]        load_i,
  input logic [N-1:0]        step_i,
  input logic [N-1:0][W-1:0] ptr_wdata_i,
  input logic [N-1:0][W-1:0] off_wdata_i,
  input logic [N-1:0][W-1:0] mod_wdata_i,
  input logic [N-1:0][W-1:0] addr_o,
  input logic [N-1:0][W-1:0] nxt_o
);
  for (genvar u = 0; u < N; u++) begin : g_chk
    a_r6_post_modify: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i[u] && !load_i[u]) |=> addr_o[u] == $past(nxt_o[u]));

    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step_i[u] && !load_i[u]) |=> $stable(addr_o[u]));

    a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i[u] |=> addr_o[u] == $past(ptr_wdata_i[u]));

    a_r3_linear_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(load_i[u]) && $past(mod_wdata_i[u]) == {W{1'b1}})
        |-> nxt_o[u] == addr_o[u] + $past(off_wdata_i[u]));

    a_r5_rev_zero_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(load_i[u]) && $past(mod_wdata_i[u]) == '0 && $past(off_wdata_i[u]) == '0)
        |-> nxt_o[u] == addr_o[u]);
  end
endmodule

bind addr_gen_dual agu_checker #(.W(W), .N(N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .step_i      (step_i),
  .ptr_wdata_i (ptr_wdata_i),
  .off_wdata_i (off_wdata_i),
  .mod_wdata_i (mod_wdata_i),
  .addr_o      (addr_o),
  .nxt_o       (nxt_o)
);

// File: tb/sim_addr_gen_dual.sv
`timescale 1ns/1ps
module sim_addr_gen_dual;
  localparam int W = 16;
  localparam int N = 2;

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic [N-1:0]        load_i = '0;
  logic [N-1:0]        step_i = '0;
  logic [N-1:0][W-1:0] ptr_wdata_i = '0;
  logic [N-1:0][W-1:0] off_wdata_i = '0;
  logic [N-1:0][W-1:0] mod_wdata_i = '0;
  logic [N-1:0][W-1:0] addr_o, nxt_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [W-1:0] m_ptr [N];
  logic [W-1:0] m_off [N];
  logic [W-1:0] m_mod [N];

  always #5 clk = ~clk;

  addr_gen_dual #(.W(W), .N(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .step_i(step_i),
    .ptr_wdata_i(ptr_wdata_i), .off_wdata_i(off_wdata_i), .mod_wdata_i(mod_wdata_i),
    .addr_o(addr_o), .nxt_o(nxt_o)
  );

  function automatic logic [W-1:0] ref_rev(logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] s;
    logic c = 1'b0;
    for (int i = W-1; i >= 0; i--) begin
      s[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    return s;
  endfunction

  function automatic logic [W-1:0] ref_mod(logic [W-1:0] p, logic [W-1:0] o, logic [W-1:0] m);
    int k = 0;
    int size = int'(m) + 1;
    int base, s;
    while ((1 << k) < size) k++;
    base = int'(p) & ~((1 << k) - 1);
    s = int'(p) + int'($signed(o));
    if (s > base + int'(m)) s = s - size;
    else if (s < base) s = s + size;
    return W'(s);
  endfunction

  function automatic logic [W-1:0] ref_next(int u);
    if (m_mod[u] == '0) return ref_rev(m_ptr[u], m_off[u]);
    if (m_mod[u] < 16'h8000) return ref_mod(m_ptr[u], m_off[u], m_mod[u]);
    return m_ptr[u] + m_off[u];
  endfunction

  function automatic string mode_tag(int u);
    if (m_mod[u] == '0) return "R5";
    if (m_mod[u] < 16'h8000) return "R4";
    if (m_mod[u] == 16'hFFFF) return "R3";
    return "R8";
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply current inputs at next edge, update model, sample at negedge
  task automatic cycle();
    for (int u = 0; u < N; u++) begin
      if (load_i[u]) begin
        m_ptr[u] = ptr_wdata_i[u];
        m_off[u] = off_wdata_i[u];
        m_mod[u] = mod_wdata_i[u];
      end else if (step_i[u]) begin
        m_ptr[u] = ref_next(u);
      end
    end
    @(negedge clk);
    load_i = '0;
    step_i = '0;
  endtask

  task automatic check_all(string tag);
    for (int u = 0; u < N; u++) begin
      chk({tag, " R6 addr"}, addr_o[u], m_ptr[u]);
      chk({tag, " ", mode_tag(u), " nxt"}, nxt_o[u], ref_next(u));
    end
  endtask

  task automatic load(int u, logic [W-1:0] p, logic [W-1:0] o, logic [W-1:0] m);
    load_i[u] = 1'b1;
    ptr_wdata_i[u] = p;
    off_wdata_i[u] = o;
    mod_wdata_i[u] = m;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rev_seq [8] = '{16'd0, 16'd4, 16'd2, 16'd6, 16'd1, 16'd5, 16'd3, 16'd7};
    void'($urandom(32'd1234));
    for (int u = 0; u < N; u++) begin
      m_ptr[u] = '0; m_off[u] = '0; m_mod[u] = '1;
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    for (int u = 0; u < N; u++) begin
      chk("R9 reset addr", addr_o[u], 16'h0);
      chk("R9 reset nxt", nxt_o[u], 16'h0);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // R3 linear wrap across top
    load(0, 16'hFFFE, 16'h0003, 16'hFFFF);
    cycle();
    chk("R3 linear wrap", nxt_o[0], 16'h0001);
    step_i[0] = 1'b1; cycle();
    chk("R6 post-modify addr", addr_o[0], 16'h0001);
    load(0, 16'h0010, 16'hFFFC, 16'hFFFF); cycle();
    chk("R3 linear negative", nxt_o[0], 16'h000C);

    // R4 modulo upper and lower wrap, M=9
    load(1, 16'h0027, 16'h0003, 16'd9); cycle();
    chk("R4 modulo upper wrap", nxt_o[1], 16'h0020);
    load(1, 16'h0021, 16'hFFFD, 16'd9); cycle();
    chk("R4 modulo lower wrap", nxt_o[1], 16'h0028);
    load(1, 16'h0022, 16'h0002, 16'd9); cycle();
    chk("R4 modulo inside", nxt_o[1], 16'h0024);

    // R8 reserved modifier acts linear
    load(0, 16'h1234, 16'h0100, 16'h8000); cycle();
    chk("R8 reserved linear", nxt_o[0], 16'h1334);

    // R5 bit-reversed walk, N=8; R1 unit 1 frozen meanwhile
    load(0, 16'h0000, 16'h0004, 16'h0000);
    load(1, 16'h0ABC, 16'h0001, 16'hFFFF);
    cycle();
    for (int i = 0; i < 8; i++) begin
      chk("R5 bit-reversed order", addr_o[0], rev_seq[i]);
      chk("R1 other unit undisturbed", addr_o[1], 16'h0ABC);
      step_i[0] = 1'b1;
      cycle();
    end
    chk("R5 walk wraps to zero", addr_o[0], 16'h0000);

    // R7 hold
    repeat (3) cycle();
    chk("R7 hold", addr_o[1], 16'h0ABC);

    // R2 load beats step
    load(1, 16'h0500, 16'h0001, 16'hFFFF);
    step_i[1] = 1'b1;
    cycle();
    chk("R2 load priority", addr_o[1], 16'h0500);

    // random mixed traffic
    for (int n = 0; n < 3000; n++) begin
      for (int u = 0; u < N; u++) begin
        int r = int'($urandom_range(0, 9));
        if (r < 2) begin
          int kind = int'($urandom_range(0, 3));
          logic [W-1:0] m, p, o;
          if (kind == 0) begin
            m = 16'hFFFF; p = W'($urandom); o = W'($urandom);
          end else if (kind == 1) begin
            m = 16'h8000 | W'($urandom_range(0, 16'h7FFE)); p = W'($urandom); o = W'($urandom);
          end else if (kind == 2) begin
            int b = 1 << $urandom_range(1, 10);
            m = 16'h0000; p = W'($urandom_range(0, b - 1)); o = W'(b / 2);
          end else begin
            int mm = int'($urandom_range(1, 300));
            int k = 0;
            int base;
            while ((1 << k) < mm + 1) k++;
            base = int'($urandom) & 16'hFFFF & ~((1 << k) - 1);
            m = W'(mm);
            p = W'(base + int'($urandom_range(0, mm)));
            o = W'(int'($urandom_range(0, 2 * (mm + 1))) - (mm + 1));
          end
          load(u, p, o, m);
          step_i[u] = 1'($urandom_range(0, 1));
        end else if (r < 8) begin
          step_i[u] = 1'b1;
        end
      end
      cycle();
      check_all("rand R1");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule